// File: doc/BRIEF.md
# Interleaved Sine Lookup Sequencer

This block feeds a sampled-data mixer with local-oscillator weights. It keeps a writable table of ten-bit codes, each code setting a charge-split weight between 0 and 1 with code 512 standing for one half (no net multiplication). Four sampling lanes work time-interleaved, so the block runs on the slow clock (one quarter of the aggregate sample rate) and presents four codes per cycle. Lane `l` in slow cycle `c` carries table entry `(4c + l) mod N`. N is the active table length, so with k sine periods stored the mixer tone sits at fS·k/N.

A host loads entries into a staging copy of the table and may request a new length. Both are applied only when the read pointer wraps, so the lanes never see part of an old period mixed with part of a new one. Each lane has its own signed trim that scales the deviation of the code from midscale. This corrects gain mismatch between the interleaved samplers. The trimmed result is clamped to the code range.

Top module: `isl_lane_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, every lane output becomes 512, the pointer returns to entry 0, the active and staged length become 128, every active and staged entry becomes 512 and every trim becomes 0.
- R2: The output register updated at the k-th rising edge after reset release (k = 1, 2, ...) holds, on lane l (bits `[10l+9:10l]` of `lane_codes`), the trimmed active entry `(4(k-1) + l) mod N`. Entry 0 comes first after reset.
- R3: The read pointer steps by 4 on each cycle and returns to 0 after the group that holds entry N-4. All lanes wrap on the same cycle, so the output pattern repeats every N/4 cycles.
- R4: A length request `len_val` is accepted only if it is a multiple of 4 from 8 to 128. Any other value is ignored and the current period length is kept.
- R5: An accepted length is staged and becomes the active N at the next wrap. The group read on the wrap cycle still uses the old N.
- R6: A table write goes to the staging copy. The active table takes a copy of the staging table on each wrap edge, so a written entry is first read in the period that follows the next wrap. A write presented on the wrap edge itself lands one period later.
- R7: Lane l outputs `code + floor((code - 512) * trim_l / 512)`, where `trim_l` is the signed 8-bit trim of that lane.
- R8: A trimmed result below 0 is output as 0 and one above 1023 as 1023.
- R9: Code 512 is output as 512 whatever the trim.
- R10: A trim write with `trim_we` high loads `trim_val` into lane `trim_lane` only. The new trim is first used by the output register update one edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow (quarter-rate) clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tbl_we | input | 1 | Write strobe for one staged table entry |
| tbl_addr | input | 7 | Entry index for the table write |
| tbl_data | input | 10 | Code written to the staged entry |
| len_we | input | 1 | Strobe for a table length request |
| len_val | input | 8 | Requested table length N |
| trim_we | input | 1 | Strobe for a lane trim write |
| trim_lane | input | 2 | Lane that the trim write selects |
| trim_val | input | 8 | Signed trim value |
| lane_codes | output | 40 | Four output codes, lane l in bits [10l+9:10l] |

## Verification
A trim write changes the lane output at the second rising edge after it is presented. A table or length write shows up only in the group read after the next wrap. A group read at pointer p is visible right after the edge that read it. The bench drives on falling edges and samples on falling edges. A model built from the requirements tracks each of these delays every cycle. Hand-worked checks align to the start of a period, detected where lane 0 reads the known first entry. From there they count whole cycles: the old entry value must still appear one cycle after a mid-period write, and the new value must appear exactly one period later.

// File: rtl/isl_pkg.sv
// Package: shared sizes of the interleaved sine lookup sequencer.
// Assumes LANES is a power of two and DEPTH a multiple of LANES.
package isl_pkg;
    localparam int LANES_DEF  = 4;
    localparam int CODE_W_DEF = 10;
    localparam int DEPTH_DEF  = 128;
    localparam int TRIM_W_DEF = 8;
endpackage

// File: rtl/isl_ptr.sv
// Module: read pointer and table length control.
// Holds a staged and an active length. Steps the pointer by LANES per cycle
// and flags the wrap cycle, on which the staged length becomes active.
// Assumes LANES is a power of two; legal lengths are multiples of LANES
// from 2*LANES to DEPTH.
module isl_ptr #(
    parameter int LANES  = isl_pkg::LANES_DEF,
    parameter int DEPTH  = isl_pkg::DEPTH_DEF,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int LEN_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_val,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              wrap_o
);
    localparam int LANE_BITS = $clog2(LANES);
    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(2 * LANES);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(DEPTH);
    localparam logic [LEN_W-1:0] STEP    = LEN_W'(LANES);

    logic [ADDR_W-1:0] ptr_q;
    logic [LEN_W-1:0]  len_act_q;
    logic [LEN_W-1:0]  len_shd_q;
    logic [LEN_W-1:0]  ptr_adv;
    logic              len_legal;
    logic              wrap;

    // Decide whether a requested length is legal.
    always_comb begin
        len_legal = (len_val >= MIN_LEN) && (len_val <= MAX_LEN) &&
                    (len_val[LANE_BITS-1:0] == '0);
    end

    // Work out the next pointer value and whether this cycle ends the period.
    always_comb begin
        ptr_adv = LEN_W'(ptr_q) + STEP;
        wrap    = (ptr_adv >= len_act_q);
    end

    // Step the pointer, or return it to 0 on the wrap cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (wrap) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_adv[ADDR_W-1:0];
        end
    end

    // Stage legal length requests; make the staged length active on a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_shd_q <= MAX_LEN;
            len_act_q <= MAX_LEN;
        end else begin
            if (len_we && len_legal) begin
                len_shd_q <= len_val;
            end
            if (wrap) begin
                len_act_q <= len_shd_q;
            end
        end
    end

    assign ptr_o  = ptr_q;
    assign wrap_o = wrap;

    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q[LANE_BITS-1:0] == '0); // R2
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q != '0) |-> (ptr_q == $past(ptr_q) + ADDR_W'(LANES))); // R3
    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        LEN_W'(ptr_q) < len_act_q); // R3
    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (len_shd_q >= MIN_LEN) && (len_shd_q <= MAX_LEN) &&
        (len_shd_q[LANE_BITS-1:0] == '0)); // R4
    AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q != '0) |-> $stable(len_act_q)); // R5
endmodule

// File: rtl/isl_table.sv
// Module: double-copy code table.
// Host writes go to the staging copy. On commit the active copy takes the
// whole staging copy. LANES read ports return consecutive active entries
// from rd_base on.
// Assumes rd_base + LANES - 1 < DEPTH (the pointer module guarantees this).
module isl_table #(
    parameter int LANES  = isl_pkg::LANES_DEF,
    parameter int CODE_W = isl_pkg::CODE_W_DEF,
    parameter int DEPTH  = isl_pkg::DEPTH_DEF,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [CODE_W-1:0]         wr_data,
    input  logic                      commit,
    input  logic [ADDR_W-1:0]         rd_base,
    output logic [LANES*CODE_W-1:0]   rd_codes
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1 << (CODE_W - 1));

    logic [CODE_W-1:0] shd_q [DEPTH];
    logic [CODE_W-1:0] act_q [DEPTH];

    // Keep the staging copy up to date with host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                shd_q[i] <= MID;
            end
        end else if (wr_en) begin
            shd_q[wr_addr] <= wr_data;
        end
    end

    // Copy the staging table into the active table at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                act_q[i] <= MID;
            end
        end else if (commit) begin
            act_q <= shd_q;
        end
    end

    // One read port per lane, at consecutive addresses.
    for (genvar l = 0; l < LANES; l++) begin : g_rd
        assign rd_codes[l*CODE_W +: CODE_W] = act_q[rd_base + ADDR_W'(l)];
    end
endmodule

// File: rtl/isl_trim.sv
// Module: gain trim for one lane.
// Holds a signed trim and outputs code + floor((code - mid) * trim / 2^(CODE_W-1)),
// clamped to 0 .. 2^CODE_W - 1. Combinational from code_i; trim registered.
module isl_trim #(
    parameter int CODE_W = isl_pkg::CODE_W_DEF,
    parameter int TRIM_W = isl_pkg::TRIM_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [TRIM_W-1:0] wr_val,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int PW    = CODE_W + 1 + TRIM_W;
    localparam int SHIFT = CODE_W - 1;
    localparam logic signed [CODE_W:0] MID_S = (CODE_W+1)'(1 << (CODE_W - 1));
    localparam logic signed [PW:0]     MAX_S = (PW+1)'((1 << CODE_W) - 1);

    logic signed [TRIM_W-1:0] trim_q;
    logic signed [CODE_W:0]   diff;
    logic signed [PW-1:0]     prod;
    logic signed [PW-1:0]     scaled;
    logic signed [PW:0]       sum;

    // Hold this lane's trim value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trim_q <= '0;
        end else if (we) begin
            trim_q <= wr_val;
        end
    end

    // Scale the deviation from midscale, add it back and clamp.
    always_comb begin
        diff   = $signed({1'b0, code_i}) - MID_S;
        prod   = PW'(diff) * PW'(trim_q);
        scaled = prod >>> SHIFT;
        sum    = $signed({{(PW-CODE_W+1){1'b0}}, code_i}) + {scaled[PW-1], scaled};
        if (sum < 0) begin
            code_o = '0;
        end else if (sum > MAX_S) begin
            code_o = '1;
        end else begin
            code_o = sum[CODE_W-1:0];
        end
    end

    always_comb begin
        if (rst_n && (code_i == CODE_W'(1 << (CODE_W - 1)))) begin
            AST_MID_UNTOUCHED: assert (code_o == code_i); // R9
        end
    end
endmodule

// File: rtl/isl_lane_seq.sv
// Module: interleaved sine lookup sequencer (top).
// Reads LANES consecutive table entries per slow cycle, trims each lane and
// registers the result. Table and length updates apply only on a wrap.
// Assumes LANES is a power of two and DEPTH a multiple of LANES.
module isl_lane_seq #(
    parameter int LANES  = isl_pkg::LANES_DEF,
    parameter int CODE_W = isl_pkg::CODE_W_DEF,
    parameter int DEPTH  = isl_pkg::DEPTH_DEF,
    parameter int TRIM_W = isl_pkg::TRIM_W_DEF,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int LEN_W  = $clog2(DEPTH) + 1,
    parameter int SEL_W  = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tbl_we,
    input  logic [ADDR_W-1:0]       tbl_addr,
    input  logic [CODE_W-1:0]       tbl_data,
    input  logic                    len_we,
    input  logic [LEN_W-1:0]        len_val,
    input  logic                    trim_we,
    input  logic [SEL_W-1:0]        trim_lane,
    input  logic [TRIM_W-1:0]       trim_val,
    output logic [LANES*CODE_W-1:0] lane_codes
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1 << (CODE_W - 1));

    logic [ADDR_W-1:0]       ptr;
    logic                    wrap;
    logic [LANES*CODE_W-1:0] raw_codes;
    logic [LANES*CODE_W-1:0] trimmed;
    logic [LANES*CODE_W-1:0] out_q;

    isl_ptr #(.LANES(LANES), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .len_we  (len_we),
        .len_val (len_val),
        .ptr_o   (ptr),
        .wrap_o  (wrap)
    );

    isl_table #(.LANES(LANES), .CODE_W(CODE_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_addr  (tbl_addr),
        .wr_data  (tbl_data),
        .commit   (wrap),
        .rd_base  (ptr),
        .rd_codes (raw_codes)
    );

    // One trim stage per lane, each with its own write select.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        isl_trim #(.CODE_W(CODE_W), .TRIM_W(TRIM_W)) u_trim (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (trim_we && (trim_lane == SEL_W'(l))),
            .wr_val (trim_val),
            .code_i (raw_codes[l*CODE_W +: CODE_W]),
            .code_o (trimmed[l*CODE_W +: CODE_W])
        );
    end

    // Register the trimmed lane codes; midscale on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= {LANES{MID}};
        end else begin
            out_q <= trimmed;
        end
    end

    assign lane_codes = out_q;

    AST_RESET_MID: assert property (@(posedge clk)
        !rst_n |=> (out_q == {LANES{MID}})); // R1
endmodule

// File: tb/tb_isl_lane_seq.sv
// Bench for isl_lane_seq: reference model plus a trim vector table and
// directed checks of ordering, wrap, length and commit timing.
module tb_isl_lane_seq;
    localparam int CLK_PERIOD = 10;
    localparam int MID = 512;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tbl_we;
    logic [6:0] tbl_addr;
    logic [9:0] tbl_data;
    logic       len_we;
    logic [7:0] len_val;
    logic       trim_we;
    logic [1:0] trim_lane;
    logic [7:0] trim_val;
    logic [39:0] lane_codes;

    int n_checks = 0;
    int n_fail   = 0;
    bit model_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isl_lane_seq dut (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .len_we(len_we), .len_val(len_val),
        .trim_we(trim_we), .trim_lane(trim_lane), .trim_val(trim_val),
        .lane_codes(lane_codes)
    );

    // Trim vectors: code, trim, expected output, requirement class.
    localparam int NV = 10;
    localparam int VEC [NV][4] = '{
        '{512,  127,  512, 9},  // R9 midscale, largest trim
        '{1023,   0, 1023, 7},  // R7 zero trim
        '{1023, 127, 1023, 8},  // R8 clamp high
        '{0,    127,    0, 8},  // R8 clamp low
        '{0,   -128,  128, 7},  // R7 negative deviation, negative trim
        '{1023,-128,  895, 7},  // R7 floor of negative result
        '{768,   64,  800, 7},  // R7
        '{256,   64,  224, 7},  // R7
        '{600,   -1,  599, 7},  // R7 floor rounds towards minus infinity
        '{700,   10,  703, 7}   // R7
    };

    function automatic int trimf(int code, int t);
        int s;
        s = code + (((code - MID) * t) >>> 9);
        if (s < 0) s = 0;
        if (s > 1023) s = 1023;
        return s;
    endfunction

    function automatic int lane(int l);
        return int'(lane_codes[l*10 +: 10]);
    endfunction

    // Reference model built from the requirements.
    int m_shd [128];
    int m_act [128];
    int m_len, m_len_shd, m_ptr;
    int m_trim [4];
    int m_out [4];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) begin
                m_shd[i] <= MID;
                m_act[i] <= MID;
            end
            for (int l = 0; l < 4; l++) begin
                m_trim[l] <= 0;
                m_out[l]  <= MID;
            end
            m_len <= 128; m_len_shd <= 128; m_ptr <= 0;
        end else begin
            for (int l = 0; l < 4; l++) m_out[l] <= trimf(m_act[m_ptr + l], m_trim[l]);
            if (m_ptr + 4 >= m_len) begin
                m_ptr <= 0;
                m_act <= m_shd;
                m_len <= m_len_shd;
            end else begin
                m_ptr <= m_ptr + 4;
            end
            if (tbl_we) m_shd[tbl_addr] <= int'(tbl_data);
            if (len_we && len_val >= 8 && len_val <= 128 && len_val[1:0] == 2'b00)
                m_len_shd <= int'(len_val);
            if (trim_we) m_trim[trim_lane] <= int'($signed(trim_val));
        end
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: wait for the falling edge, then compare with the model.
    task automatic tick();
        @(negedge clk);
        if (model_on) begin
            for (int l = 0; l < 4; l++) check("R2 model lane", lane(l), m_out[l]);
        end
    endtask

    task automatic sync_period();
        for (int i = 0; i < 40; i++) begin
            if (lane(0) == 0) break;
            tick();
        end
    endtask

    initial begin
        int wd = 0;
        while (wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", wd);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 0; tbl_we = 0; tbl_addr = 0; tbl_data = 0;
        len_we = 0; len_val = 0; trim_we = 0; trim_lane = 0; trim_val = 0;
        repeat (3) tick();
        for (int l = 0; l < 4; l++) check("R1 reset midscale", lane(l), MID);
        rst_n = 1;
        model_on = 1;
        tick();
        check("R2 first group after reset", lane(0), MID);

        // Load a ramp: entry i holds 8*i.
        for (int i = 0; i < 128; i++) begin
            tbl_we = 1; tbl_addr = 7'(i); tbl_data = 10'(i * 8);
            tick();
        end
        tbl_we = 0;
        repeat (70) tick();
        sync_period();
        for (int l = 0; l < 4; l++) check("R2 period start lane", lane(l), 8 * l);
        tick();
        for (int l = 0; l < 4; l++) check("R2 second group lane", lane(l), 32 + 8 * l);

        // R6: entry 8 rewritten as it is about to be read; old value must show.
        tbl_we = 1; tbl_addr = 7'd8; tbl_data = 10'd777;
        tick();
        tbl_we = 0;
        check("R6 old entry before wrap", lane(0), 64);
        repeat (30) tick();
        check("R3 wrap after 32 cycles", lane(0), 0);
        tick(); tick();
        check("R6 new entry after wrap", lane(0), 777);

        // R4: illegal lengths must be ignored.
        len_we = 1; len_val = 8'd10; tick();
        len_val = 8'd4; tick();
        len_val = 8'd132; tick();
        len_we = 0;
        sync_period();
        repeat (31) tick();
        check("R4 last group kept", lane(0), 992);
        tick();
        check("R4 period still 32", lane(0), 0);

        // R5: a new length waits for the wrap.
        len_we = 1; len_val = 8'd8; tick();
        len_we = 0;
        tick();
        check("R5 old length until wrap", lane(0), 777);
        sync_period();
        tick();
        check("R5 new length group 1", lane(0), 32);
        tick();
        check("R5 new length wraps", lane(0), 0);

        // R10: trim one lane only; model checks every lane each cycle.
        trim_we = 1; trim_lane = 2'd2; trim_val = 8'sd127; tick();
        trim_we = 0;
        tick();
        check("R10 trimmed lane saturates", lane(2), 0);
        check("R10 other lane untouched", lane(1) == 8 || lane(1) == 40 ? 1 : 0, 1);
        repeat (3) tick();
        trim_we = 1; trim_val = 8'd0; tick();
        trim_we = 0;

        // Trim vector table.
        for (int v = 0; v < NV; v++) begin
            string tag;
            case (VEC[v][3])
                8: tag = "R8 clamp vector";
                9: tag = "R9 midscale vector";
                default: tag = "R7 trim vector";
            endcase
            for (int i = 0; i < 8; i++) begin
                tbl_we = 1; tbl_addr = 7'(i); tbl_data = 10'(VEC[v][0]);
                tick();
            end
            tbl_we = 0;
            for (int l = 0; l < 4; l++) begin
                trim_we = 1; trim_lane = 2'(l); trim_val = 8'(VEC[v][1]);
                tick();
            end
            trim_we = 0;
            repeat (6) tick();
            for (int l = 0; l < 4; l++) check(tag, lane(l), VEC[v][2]);
        end

        // R1: reset in mid-run.
        rst_n = 0;
        tick();
        for (int l = 0; l < 4; l++) check("R1 mid-run reset", lane(l), MID);
        rst_n = 1;
        tick();
        check("R1 table back to midscale", lane(0), MID);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule